// File: doc/BRIEF.md
# Two-Stage Crosspoint Route Controller

This block sets and applies the routing of a non-blocking single-bit crosspoint with 34 inputs and 34 outputs. Each output has its own 34:1 selector, so it can take any input. One input may feed any number of outputs.

Routes are written in two stages. A control port first writes new selections into a per-output staging register. A global commit then copies every staging register into the active register that drives the selectors, so all outputs switch together. While a route is being staged, the active routing does not change.

Two mode bits choose how outputs are addressed and where the input comes from. Outputs are addressed either by a single binary index or by a bitmask of outputs. The input is either the supplied input code or the output's own index, which is the pass-through route. The design is fully synchronous to one clock.

Top module: `xpt_route_ctrl`

## Requirements
- R1: A synchronous reset sets the staged and active selection of every output k to input k, so after reset `dout[k]` equals `din[k]`.
- R2: Any input can drive any number of outputs at once, up to and including all 34 (broadcast).
- R3: `mode[0]`=1 selects bitmask addressing of outputs and `mode[0]`=0 selects a single binary output index. `mode[1]`=1 selects the pass-through input and `mode[1]`=0 selects the input given by `in_sel`.
- R4: With binary addressing, only `out_sel[5:0]` is used. Codes 0 to 31 name outputs 0 to 31, any code with bits [5:4]=10 names output 32, and any code with bits [5:4]=11 names output 33.
- R5: `in_sel` is decoded in the same way: 0 to 31 are inputs 0 to 31, bits [5:4]=10 is input 32 and bits [5:4]=11 is input 33.
- R6: With bitmask addressing, `out_sel[i]`=1 selects output i, and every selected output is staged in the same clock.
- R7: In pass-through mode, `in_sel` has no effect and each selected output k is staged with input k.
- R8: A staging register takes its new value on every clock edge at which `load` is high and the output is selected. Unselected outputs, and all outputs while `load` is low, keep their staged value.
- R9: Staging never changes `dout`, and several loads may be staged before a single commit.
- R10: On every clock edge at which `commit` is high, every active register takes the staged value. While `commit` is low, the active routing holds, and outputs whose staged value did not change keep their route.
- R11: When `load` and `commit` are high on the same edge, the newly loaded selection is active right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Stage selections for the addressed outputs |
| commit | input | 1 | Copy all staged selections to the active registers |
| mode | input | 2 | Bit 0: bitmask addressing; bit 1: pass-through input |
| in_sel | input | 6 | Input code |
| out_sel | input | 34 | Output bitmask, or a binary index in bits [5:0] |
| din | input | 34 | Crosspoint data inputs |
| dout | output | 34 | Crosspoint data outputs |

## Verification
The bench builds the block with its package defaults: a 6-bit port code, which gives 34 ports. At that size the two folded codes, 32 and 33, are reachable both as output indices and as input codes, and a full 34-bit mask is enough to broadcast one input to every output. Random data on `din` in every cycle makes each output's selected input visible at the port. This shows the active routing after each staging and commit sequence in all four modes.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
    localparam int CODE_W   = 6;
    localparam int BIN_SPAN = 2 ** (CODE_W - 1);
    localparam int NPORT    = BIN_SPAN + 2;

    typedef logic [CODE_W-1:0]            port_idx_t;
    typedef port_idx_t [NPORT-1:0]        route_t;
    typedef logic [NPORT-1:0]             port_vec_t;

    typedef enum logic [1:0] {
        MD_SEQ_USER = 2'b00,
        MD_MC_USER  = 2'b01,
        MD_SEQ_PASS = 2'b10,
        MD_MC_PASS  = 2'b11
    } prog_mode_e;

    function automatic port_idx_t code_to_port(input port_idx_t code);
        port_idx_t r;
        if (!code[CODE_W-1]) r = code;
        else r = port_idx_t'(BIN_SPAN) + port_idx_t'(code[CODE_W-2]);
        return r;
    endfunction

    function automatic route_t identity_route();
        route_t r;
        for (int k = 0; k < NPORT; k++) r[k] = port_idx_t'(k);
        return r;
    endfunction
endpackage

// File: rtl/xpt_addr_dec.sv
module xpt_addr_dec
    import xpt_pkg::*;
(
    input  logic [1:0] mode,
    input  port_idx_t  in_sel,
    input  port_vec_t  out_sel,
    output port_vec_t  hit,
    output route_t     val
);
    prog_mode_e md;
    logic       use_mask;
    logic       use_pass;
    port_idx_t  out_idx;
    port_idx_t  in_idx;

    assign md       = prog_mode_e'(mode);
    assign use_mask = (md == MD_MC_USER) || (md == MD_MC_PASS);
    assign use_pass = (md == MD_SEQ_PASS) || (md == MD_MC_PASS);
    assign out_idx  = code_to_port(out_sel[CODE_W-1:0]);
    assign in_idx   = code_to_port(in_sel);

    always_comb begin
        if (use_mask) begin
            hit = out_sel;
        end else begin
            hit = '0;
            hit[out_idx] = 1'b1;
        end
    end

    for (genvar g = 0; g < NPORT; g++) begin : g_val
        assign val[g] = use_pass ? port_idx_t'(g) : in_idx;
    end
endmodule

// File: rtl/xpt_route_regs.sv
module xpt_route_regs
    import xpt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  logic      commit,
    input  port_vec_t hit,
    input  route_t    val,
    output route_t    prog_q,
    output route_t    cfg_q
);
    route_t prog_nxt;

    for (genvar g = 0; g < NPORT; g++) begin : g_nxt
        assign prog_nxt[g] = (load && hit[g]) ? val[g] : prog_q[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prog_q <= identity_route();
            cfg_q  <= identity_route();
        end else begin
            prog_q <= prog_nxt;
            if (commit) cfg_q <= prog_nxt;
        end
    end
endmodule

// File: rtl/xpt_sel_mux.sv
module xpt_sel_mux
    import xpt_pkg::*;
(
    input  route_t    cfg,
    input  port_vec_t din,
    output port_vec_t dout
);
    for (genvar g = 0; g < NPORT; g++) begin : g_mux
        assign dout[g] = din[cfg[g]];
    end
endmodule

// File: rtl/xpt_route_ctrl.sv
module xpt_route_ctrl
    import xpt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  logic        commit,
    input  logic [1:0]  mode,
    input  logic [5:0]  in_sel,
    input  logic [33:0] out_sel,
    input  logic [33:0] din,
    output logic [33:0] dout
);
    port_vec_t hit;
    route_t    val;
    route_t    prog_q;
    route_t    cfg_q;

    xpt_addr_dec u_dec (
        .mode    (mode),
        .in_sel  (in_sel),
        .out_sel (out_sel),
        .hit     (hit),
        .val     (val)
    );

    xpt_route_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .commit (commit),
        .hit    (hit),
        .val    (val),
        .prog_q (prog_q),
        .cfg_q  (cfg_q)
    );

    xpt_sel_mux u_mux (
        .cfg  (cfg_q),
        .din  (din),
        .dout (dout)
    );
endmodule

// File: rtl/xpt_route_chk.sv
module xpt_route_chk
    import xpt_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        load,
    input logic        commit,
    input logic [1:0]  mode,
    input logic [33:0] out_sel,
    input logic [33:0] din,
    input logic [33:0] dout,
    input route_t      prog_q,
    input route_t      cfg_q
);
    AST_RESET_PASS: assert property (@(posedge clk) $past(rst) |-> dout == din); // R1

    AST_PROG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(load)) |-> $stable(prog_q)); // R8

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(commit)) |-> $stable(cfg_q)); // R10

    AST_COMMIT_COPY: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(commit)) |-> cfg_q == prog_q); // R11

    for (genvar g = 0; g < NPORT; g++) begin : g_pass
        AST_PASS_SELF: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(load && mode == 2'b11 && out_sel[g]))
            |-> prog_q[g] == port_idx_t'(g)); // R7
    end
endmodule

bind xpt_route_ctrl xpt_route_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .commit  (commit),
    .mode    (mode),
    .out_sel (out_sel),
    .din     (din),
    .dout    (dout),
    .prog_q  (prog_q),
    .cfg_q   (cfg_q)
);

// File: tb/sim_xpt_route_ctrl.sv
module sim_xpt_route_ctrl;
    localparam int TCK = 10;
    localparam int NP  = 34;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load = 1'b0;
    logic        commit = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [5:0]  in_sel = '0;
    logic [33:0] out_sel = '0;
    logic [33:0] din = '0;
    logic [33:0] dout;

    int    n_checks = 0;
    int    n_errs = 0;
    int    m_prog[NP];
    int    m_cfg[NP];
    string tag = "R1";

    always #(TCK/2) clk = ~clk;

    xpt_route_ctrl u0 (
        .clk(clk), .rst(rst), .load(load), .commit(commit), .mode(mode),
        .in_sel(in_sel), .out_sel(out_sel), .din(din), .dout(dout)
    );

    function automatic int dec_code(input int c);
        if (c < 32) return c;
        if (c < 48) return 32;
        return 33;
    endfunction

    task automatic check_out();
        logic [33:0] exp;
        for (int k = 0; k < NP; k++) exp[k] = din[m_cfg[k]];
        n_checks++;
        if (dout !== exp) begin
            n_errs++;
            $display("FAIL %s: dout=%h expected=%h", tag, dout, exp);
        end
    endtask

    // One clock: inputs already set, model advanced, result checked at negedge.
    task automatic cyc();
        int nxt[NP];
        bit sel;
        din = {$urandom, $urandom};
        for (int k = 0; k < NP; k++) begin
            nxt[k] = m_prog[k];
            if (mode[0]) sel = out_sel[k];
            else sel = (dec_code(int'(out_sel[5:0])) == k);
            if (load && sel) nxt[k] = mode[1] ? k : dec_code(int'(in_sel));
        end
        @(posedge clk);
        @(negedge clk);
        for (int k = 0; k < NP; k++) begin
            if (rst) begin
                m_prog[k] = k;
                m_cfg[k] = k;
            end else begin
                m_prog[k] = nxt[k];
                if (commit) m_cfg[k] = nxt[k];
            end
        end
        check_out();
    endtask

    task automatic idle(input int n);
        load = 0; commit = 0;
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic seq_load(input logic [1:0] md, input int oc, input int ic);
        mode = md; load = 1; commit = 0;
        out_sel = {$urandom, $urandom};
        out_sel[5:0] = 6'(oc);
        in_sel = 6'(ic);
        cyc();
        load = 0;
    endtask

    task automatic mc_load(input logic [1:0] md, input logic [33:0] msk, input int ic);
        mode = md; load = 1; commit = 0; out_sel = msk; in_sel = 6'(ic);
        cyc();
        load = 0;
    endtask

    task automatic do_commit();
        load = 0; commit = 1;
        cyc();
        commit = 0;
    endtask

    initial begin
        #(TCK * 200000);
        n_errs++;
        n_checks++;
        $display("FAIL watchdog: timeout, expected completion");
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        for (int k = 0; k < NP; k++) begin m_prog[k] = 0; m_cfg[k] = 0; end
        @(negedge clk);
        rst = 1; tag = "R1";
        for (int i = 0; i < 3; i++) begin
            din = {$urandom, $urandom};
            @(posedge clk); @(negedge clk);
            for (int k = 0; k < NP; k++) begin m_prog[k] = k; m_cfg[k] = k; end
        end
        check_out();
        rst = 0;
        idle(3);

        // R9: staged loads do not reach dout
        tag = "R9";
        seq_load(2'b00, 3, 10);
        idle(2);
        seq_load(2'b00, 7, 20);
        seq_load(2'b00, 0, 31);
        idle(2);
        // R10: commit applies all staged routes together
        tag = "R10";
        do_commit();
        idle(3);

        // R4 / R5: folded codes for ports 32 and 33
        tag = "R4";
        seq_load(2'b00, 6'b101010, 5);
        seq_load(2'b00, 6'b111111, 9);
        do_commit();
        idle(2);
        tag = "R5";
        seq_load(2'b00, 12, 6'b100111);
        seq_load(2'b00, 13, 6'b110000);
        seq_load(2'b00, 14, 6'b011111);
        do_commit();
        idle(2);

        // R6: mask bits 1, 2, 5 take input 1
        tag = "R6";
        mc_load(2'b01, 34'b100110, 1);
        do_commit();
        idle(2);

        // R2: broadcast one input to every output
        tag = "R2";
        mc_load(2'b01, {34{1'b1}}, 6'b111010);
        do_commit();
        idle(3);

        // R7: pass-through modes ignore in_sel
        tag = "R7";
        seq_load(2'b10, 5, 17);
        seq_load(2'b10, 6'b110101, 2);
        mc_load(2'b11, 34'h2_AAAA_5555, 6'h3F);
        do_commit();
        idle(2);

        // R8: load held high restages each cycle; unselected outputs hold
        tag = "R8";
        mode = 2'b00; load = 1; commit = 0;
        for (int i = 0; i < 6; i++) begin
            out_sel = '0;
            out_sel[5:0] = 6'(i + 20);
            in_sel = 6'(i * 5);
            cyc();
        end
        load = 0;
        do_commit();
        idle(2);

        // R11: load and commit on the same edge
        tag = "R11";
        mode = 2'b00; load = 1; commit = 1; out_sel = 34'd8; in_sel = 6'd30;
        cyc();
        mode = 2'b01; out_sel = 34'h3_0000_00F0; in_sel = 6'd4;
        cyc();
        load = 0; commit = 0;
        idle(2);

        // R3: random mix of all four modes
        tag = "R3";
        for (int i = 0; i < 400; i++) begin
            mode = 2'($urandom);
            load = 1'($urandom % 3 != 0);
            commit = 1'($urandom % 4 == 0);
            in_sel = 6'($urandom);
            out_sel = {$urandom, $urandom};
            if (!mode[0] || ($urandom % 2 == 0)) out_sel[33:6] = 28'($urandom);
            cyc();
        end
        idle(2);
        do_commit();
        idle(2);

        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule